// File: doc/BRIEF.md
# Packed-SIMD Accumulator Vector ALU

This unit is the arithmetic stage of a near-memory vector engine. On every accepted beat it takes one 32-bit word read from the vector register memory and combines it with one of three things: a second vector word, a scalar from the controller's general registers copied into every lane, or the contents of a private accumulator register. A word is split into four 8-bit lanes, two 16-bit lanes or one 32-bit lane, chosen per beat. No carry crosses a lane boundary.

The accumulator forms keep partial sums inside the unit. A run of multiply-accumulate beats therefore never writes intermediate results back to the register memory and never reads them again. With 8-bit elements, each beat performs four multiply-accumulates. Every operation, including move and slide, has an accumulator-with-vector form and an accumulator-with-scalar form.

The result is registered and appears one cycle after acceptance, marked by a one-cycle valid pulse. A synchronous clear input empties the accumulator. The slide operation carries the top element of one beat into the bottom lane of the next beat, so that a vector longer than one word can be slid across several beats.

Top module: `acc_simd_alu`

## Requirements
- R1: After reset, `res_valid_o` and `res_o` are 0 and the accumulator holds 0. `in_ready_o` is 1 from the first clock edge after reset is released.
- R2: A beat is accepted on a rising edge where `in_valid_i` and `in_ready_o` are both 1. `res_valid_o` is 1 in the cycle after an accepted beat and 0 after any cycle with no accepted beat. `res_o` keeps its last value while no beat is accepted.
- R3: The `ew_i` input selects the element width: 0 gives four 8-bit lanes, 1 gives two 16-bit lanes, and 2 or 3 give one 32-bit lane. Lanes are computed independently and wrap modulo the element width.
- R4: The `op_i` input selects the operation: 0 gives X+Y, 1 gives X−Y, 2 gives the low element bits of X·Y, 3 gives X + M·Y (M is `vec_b_i`), 4 gives Y, and 5 gives a slide. The values 6 and 7 behave like 4.
- R5: The `src_i` input selects the operands: 0 gives X=`vec_a_i`, Y=`vec_b_i`; 1 gives X=`vec_a_i`, Y=scalar; 2 gives X=accumulator, Y=`vec_a_i`; 3 gives X=accumulator, Y=scalar.
- R6: For the scalar forms (`src_i` 1 and 3), the low element-width bits of `scalar_i` are replicated into every lane.
- R7: An accepted beat with `src_i` 2 or 3 stores its result in the accumulator. Beats with `src_i` 0 or 1 leave the accumulator unchanged.
- R8: Beats can be accepted on consecutive cycles, each delivering a result, so an 8-bit multiply-accumulate stream completes four lane products per cycle.
- R9: When `acc_clr_i` is 1 at a rising edge, the accumulator becomes 0, even if an accumulator-form beat is accepted in the same cycle. That beat's `res_o` still shows the value computed from the old accumulator.
- R10: A slide (`op_i`=5) moves each element of Y one lane toward the most significant end. Lane 0 is filled with 0 when `first_beat_i` is 1; otherwise it takes the top element of Y from the last accepted slide beat. Beats of other operations do not change that carried element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Beat request |
| in_ready_o | output | 1 | Unit can accept a beat |
| op_i | input | 3 | Operation code |
| src_i | input | 2 | Operand form select |
| ew_i | input | 2 | Element width select |
| vec_a_i | input | 32 | Vector word from the register memory |
| vec_b_i | input | 32 | Second vector word, or multiplicand for op 3 |
| scalar_i | input | 32 | Scalar from a controller general register |
| first_beat_i | input | 1 | Marks the first beat of a slide |
| acc_clr_i | input | 1 | Synchronous accumulator clear |
| res_valid_o | output | 1 | Result valid pulse |
| res_o | output | 32 | Registered result |

## Verification
Two things can happen to the accumulator in the same cycle: a clear and the write-back of an accumulator-form beat. The bench raises `acc_clr_i` in the same cycle that an accumulator-form add is accepted. It checks that `res_o` still carries the sum computed from the old accumulator. It then reads the accumulator back with an add of scalar zero and expects 0. The checker separately requires the accumulator to be zero after any clear. It also requires the accumulator to equal the published result after any write that had no clear beside it.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int WORD_W   = 32;
  localparam int ELEM_MIN = 8;
  localparam int LANES    = WORD_W / ELEM_MIN;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_MUL   = 3'd2,
    OP_MACC  = 3'd3,
    OP_MOV   = 3'd4,
    OP_SLIDE = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    SRC_VV = 2'd0,
    SRC_VX = 2'd1,
    SRC_AV = 2'd2,
    SRC_AX = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    EW_8   = 2'd0,
    EW_16  = 2'd1,
    EW_32  = 2'd2,
    EW_RSV = 2'd3
  } ew_e;

  function automatic int elem_bits(ew_e ew);
    case (ew)
      EW_8:    return ELEM_MIN;
      EW_16:   return 2 * ELEM_MIN;
      default: return WORD_W;
    endcase
  endfunction

  function automatic word_t elem_mask(int e);
    if (e >= WORD_W) return '1;
    return (word_t'(1) << e) - word_t'(1);
  endfunction

  function automatic word_t broadcast(word_t s, ew_e ew);
    int    e;
    word_t mask;
    word_t r;
    e    = elem_bits(ew);
    mask = elem_mask(e);
    r    = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i * e < WORD_W) r = r | ((s & mask) << (i * e));
    end
    return r;
  endfunction

  function automatic word_t elem_calc(op_e op, word_t xe, word_t ye, word_t me);
    case (op)
      OP_ADD:  return xe + ye;
      OP_SUB:  return xe - ye;
      OP_MUL:  return xe * ye;
      OP_MACC: return xe + me * ye;
      default: return ye;
    endcase
  endfunction

  function automatic word_t simd_arith(op_e op, word_t x, word_t y, word_t m, ew_e ew);
    int    e;
    word_t mask;
    word_t r;
    word_t t;
    e    = elem_bits(ew);
    mask = elem_mask(e);
    r    = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i * e < WORD_W) begin
        t = elem_calc(op, (x >> (i * e)) & mask, (y >> (i * e)) & mask,
                      (m >> (i * e)) & mask);
        r = r | ((t & mask) << (i * e));
      end
    end
    return r;
  endfunction

  function automatic word_t slide_up(word_t y, word_t cin, logic first, ew_e ew);
    int    e;
    word_t fill;
    e    = elem_bits(ew);
    fill = first ? '0 : (cin & elem_mask(e));
    return (y << e) | fill;
  endfunction

  function automatic word_t top_elem(word_t y, ew_e ew);
    int e;
    e = elem_bits(ew);
    return (y >> (WORD_W - e)) & elem_mask(e);
  endfunction

endpackage

// File: rtl/acc_alu_opsel.sv
module acc_alu_opsel
  import acc_alu_pkg::*;
(
  input  src_e  src_i,
  input  ew_e   ew_i,
  input  word_t vec_a_i,
  input  word_t vec_b_i,
  input  word_t scalar_i,
  input  word_t acc_i,
  output word_t x_o,
  output word_t y_o,
  output word_t m_o
);

  word_t splat;
  logic  use_acc;

  assign splat   = broadcast(scalar_i, ew_i);
  assign use_acc = (src_i == SRC_AV) || (src_i == SRC_AX);

  always_comb begin
    x_o = use_acc ? acc_i : vec_a_i;
    case (src_i)
      SRC_VV:  y_o = vec_b_i;
      SRC_AV:  y_o = vec_a_i;
      default: y_o = splat;
    endcase
    m_o = vec_b_i;
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
(
  input  op_e   op_i,
  input  ew_e   ew_i,
  input  word_t x_i,
  input  word_t y_i,
  input  word_t m_i,
  input  word_t carry_i,
  input  logic  first_i,
  output word_t res_o,
  output word_t carry_nxt_o
);

  word_t arith_res;
  word_t slide_res;

  assign arith_res   = simd_arith(op_i, x_i, y_i, m_i, ew_i);
  assign slide_res   = slide_up(y_i, carry_i, first_i, ew_i);
  assign carry_nxt_o = top_elem(y_i, ew_i);

  always_comb begin
    if (op_i == OP_SLIDE) res_o = slide_res;
    else                  res_o = arith_res;
  end

endmodule

// File: rtl/acc_alu_state.sv
module acc_alu_state
  import acc_alu_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  acc_wr_i,
  input  word_t acc_d_i,
  input  logic  slide_fire_i,
  input  word_t carry_d_i,
  output word_t acc_o,
  output word_t carry_o,
  output logic  clr_wins_o
);

  word_t acc_q;
  word_t carry_q;

  assign clr_wins_o = clr_i & acc_wr_i;
  assign acc_o      = acc_q;
  assign carry_o    = carry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= '0;
    end else begin
      if (clr_i)         acc_q <= '0;
      else if (acc_wr_i) acc_q <= acc_d_i;
      if (slide_fire_i)  carry_q <= carry_d_i;
    end
  end

endmodule

// File: rtl/acc_simd_alu.sv
module acc_simd_alu
  import acc_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [2:0]        op_i,
  input  logic [1:0]        src_i,
  input  logic [1:0]        ew_i,
  input  logic [WORD_W-1:0] vec_a_i,
  input  logic [WORD_W-1:0] vec_b_i,
  input  logic [WORD_W-1:0] scalar_i,
  input  logic              first_beat_i,
  input  logic              acc_clr_i,
  output logic              res_valid_o,
  output logic [WORD_W-1:0] res_o
);

  op_e   op;
  src_e  src;
  ew_e   ew;
  logic  ready_q;
  logic  fire;
  logic  acc_wr;
  logic  slide_fire;
  logic  clr_wins;
  word_t x;
  word_t y;
  word_t m;
  word_t acc_q;
  word_t carry_q;
  word_t carry_nxt;
  word_t res_d;
  word_t res_q;
  logic  res_valid_q;

  assign op         = op_e'(op_i);
  assign src        = src_e'(src_i);
  assign ew         = ew_e'(ew_i);
  assign fire       = in_valid_i & ready_q;
  assign acc_wr     = fire & ((src == SRC_AV) || (src == SRC_AX));
  assign slide_fire = fire & (op == OP_SLIDE);

  acc_alu_opsel u_opsel (
    .src_i    (src),
    .ew_i     (ew),
    .vec_a_i  (vec_a_i),
    .vec_b_i  (vec_b_i),
    .scalar_i (scalar_i),
    .acc_i    (acc_q),
    .x_o      (x),
    .y_o      (y),
    .m_o      (m)
  );

  acc_alu_core u_core (
    .op_i        (op),
    .ew_i        (ew),
    .x_i         (x),
    .y_i         (y),
    .m_i         (m),
    .carry_i     (carry_q),
    .first_i     (first_beat_i),
    .res_o       (res_d),
    .carry_nxt_o (carry_nxt)
  );

  acc_alu_state u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (acc_clr_i),
    .acc_wr_i     (acc_wr),
    .acc_d_i      (res_d),
    .slide_fire_i (slide_fire),
    .carry_d_i    (carry_nxt),
    .acc_o        (acc_q),
    .carry_o      (carry_q),
    .clr_wins_o   (clr_wins)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q     <= 1'b0;
      res_valid_q <= 1'b0;
      res_q       <= '0;
    end else begin
      ready_q     <= 1'b1;
      res_valid_q <= fire;
      if (fire) res_q <= res_d;
    end
  end

  assign in_ready_o  = ready_q;
  assign res_valid_o = res_valid_q;
  assign res_o       = res_q;

endmodule

// File: rtl/acc_simd_alu_chk.sv
module acc_simd_alu_chk
  import acc_alu_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fire,
  input logic       acc_wr,
  input logic       clr_wins,
  input word_t      acc_q,
  input logic       acc_clr_i,
  input logic       res_valid_o,
  input word_t      res_o,
  input logic [2:0] op_i,
  input logic [1:0] ew_i,
  input logic       first_beat_i
);

  // R2
  valid_after_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> res_valid_o);

  // R2
  quiet_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !res_valid_o);

  // R9
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_clr_i || clr_wins) |=> (acc_q == '0));

  // R7
  acc_follows_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && !acc_clr_i) |=> (acc_q == res_o));

  // R7
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_wr && !acc_clr_i) |=> $stable(acc_q));

  // R10
  slide_first_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op_i == 3'd5 && first_beat_i && ew_i == 2'd0) |=> (res_o[7:0] == 8'h00));

endmodule

bind acc_simd_alu acc_simd_alu_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fire         (fire),
  .acc_wr       (acc_wr),
  .clr_wins     (clr_wins),
  .acc_q        (acc_q),
  .acc_clr_i    (acc_clr_i),
  .res_valid_o  (res_valid_o),
  .res_o        (res_o),
  .op_i         (op_i),
  .ew_i         (ew_i),
  .first_beat_i (first_beat_i)
);

// File: tb/acc_simd_alu_test.sv
`timescale 1ns/100ps
module acc_simd_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  op = '0;
  logic [1:0]  src = '0;
  logic [1:0]  ew = '0;
  logic [31:0] va = '0;
  logic [31:0] vb = '0;
  logic [31:0] sc = '0;
  logic        first = 1'b0;
  logic        clr = 1'b0;
  logic        res_valid;
  logic [31:0] res;

  int total = 0;
  int bad = 0;
  logic [31:0] model_acc = '0;
  logic [31:0] model_carry = '0;

  always #2.5 clk = ~clk;

  acc_simd_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .src_i(src), .ew_i(ew), .vec_a_i(va), .vec_b_i(vb), .scalar_i(sc),
    .first_beat_i(first), .acc_clr_i(clr), .res_valid_o(res_valid), .res_o(res)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_splat(logic [31:0] s, logic [1:0] w);
    case (w)
      2'd0:    return {4{s[7:0]}};
      2'd1:    return {2{s[15:0]}};
      default: return s;
    endcase
  endfunction

  function automatic logic [31:0] m_y(logic [1:0] sv, logic [1:0] w, logic [31:0] a, logic [31:0] b, logic [31:0] s);
    case (sv)
      2'd0:    return b;
      2'd2:    return a;
      default: return m_splat(s, w);
    endcase
  endfunction

  function automatic logic [31:0] m_elem(logic [2:0] o, logic [31:0] xe, logic [31:0] ye, logic [31:0] me);
    case (o)
      3'd0:    return xe + ye;
      3'd1:    return xe - ye;
      3'd2:    return xe * ye;
      3'd3:    return xe + me * ye;
      default: return ye;
    endcase
  endfunction

  function automatic logic [31:0] m_calc(logic [2:0] o, logic [1:0] sv, logic [1:0] w,
                                         logic [31:0] a, logic [31:0] b, logic [31:0] s, logic f);
    logic [31:0] x, y, r, t;
    x = (sv >= 2'd2) ? model_acc : a;
    y = m_y(sv, w, a, b, s);
    r = '0;
    if (o == 3'd5) begin
      case (w)
        2'd0: for (int k = 0; k < 4; k++) r[k*8 +: 8] = (k == 0) ? (f ? 8'h0 : model_carry[7:0]) : y[(k-1)*8 +: 8];
        2'd1: r = {y[15:0], (f ? 16'h0 : model_carry[15:0])};
        default: r = f ? 32'h0 : model_carry;
      endcase
    end else begin
      case (w)
        2'd0: for (int k = 0; k < 4; k++) begin
          t = m_elem(o, {24'h0, x[k*8 +: 8]}, {24'h0, y[k*8 +: 8]}, {24'h0, b[k*8 +: 8]});
          r[k*8 +: 8] = t[7:0];
        end
        2'd1: for (int k = 0; k < 2; k++) begin
          t = m_elem(o, {16'h0, x[k*16 +: 16]}, {16'h0, y[k*16 +: 16]}, {16'h0, b[k*16 +: 16]});
          r[k*16 +: 16] = t[15:0];
        end
        default: r = m_elem(o, x, y, b);
      endcase
    end
    return r;
  endfunction

  task automatic issue(input logic [2:0] o, input logic [1:0] sv, input logic [1:0] w,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] s,
                       input logic f, input logic c, input string tag);
    logic [31:0] exp, y;
    exp = m_calc(o, sv, w, a, b, s, f);
    y   = m_y(sv, w, a, b, s);
    @(negedge clk);
    op = o; src = sv; ew = w; va = a; vb = b; sc = s; first = f; clr = c; in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0; clr = 1'b0;
    chk(res_valid === 1'b1, {tag, " valid"}, {31'h0, res_valid}, 32'h1);
    chk(res === exp, {tag, " result"}, res, exp);
    if (c) model_acc = '0;
    else if (sv >= 2'd2) model_acc = exp;
    if (o == 3'd5) begin
      case (w)
        2'd0:    model_carry = {24'h0, y[31:24]};
        2'd1:    model_carry = {16'h0, y[31:16]};
        default: model_carry = y;
      endcase
    end
  endtask

  task automatic readback(input string tag);
    issue(3'd0, 2'd3, 2'd2, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(res_valid === 1'b0, "R1 reset valid", {31'h0, res_valid}, 32'h0);
    chk(res === 32'h0, "R1 reset result", res, 32'h0);
    @(negedge clk);
    chk(in_ready === 1'b1, "R1 ready after reset", {31'h0, in_ready}, 32'h1);
    readback("R1 accumulator zero");
    chk(res === 32'h0, "R1 accumulator reads 0", res, 32'h0);
  endtask

  task automatic t_idle;
    logic [31:0] held;
    held = res;
    @(posedge clk); #1;
    chk(res_valid === 1'b0, "R2 no beat no valid", {31'h0, res_valid}, 32'h0);
    chk(res === held, "R2 result held", res, held);
  endtask

  task automatic t_vector_ops;
    issue(3'd0, 2'd0, 2'd0, 32'hFF7F_0102, 32'h0181_FF03, 32'h0, 1'b0, 1'b0, "R3 R4 R5 add e8 wrap");
    issue(3'd1, 2'd0, 2'd0, 32'h0010_2030, 32'h0120_1010, 32'h0, 1'b0, 1'b0, "R4 sub e8");
    issue(3'd2, 2'd0, 2'd0, 32'h1003_FF40, 32'h1005_0204, 32'h0, 1'b0, 1'b0, "R4 mul e8 low bits");
    issue(3'd3, 2'd0, 2'd1, 32'h0001_0002, 32'h0100_0300, 32'h0, 1'b0, 1'b0, "R4 macc e16");
    issue(3'd4, 2'd0, 2'd0, 32'h1111_1111, 32'hCAFE_F00D, 32'h0, 1'b0, 1'b0, "R4 mov");
    issue(3'd6, 2'd0, 2'd0, 32'h1111_1111, 32'h1234_5678, 32'h0, 1'b0, 1'b0, "R4 op6 as mov");
  endtask

  task automatic t_widths;
    issue(3'd0, 2'd0, 2'd1, 32'h0000_FFFF, 32'h0000_0001, 32'h0, 1'b0, 1'b0, "R3 e16 no lane carry");
    issue(3'd0, 2'd0, 2'd2, 32'h0000_FFFF, 32'h0000_0001, 32'h0, 1'b0, 1'b0, "R3 e32 full carry");
    issue(3'd2, 2'd0, 2'd3, 32'h0001_0003, 32'h0002_0005, 32'h0, 1'b0, 1'b0, "R3 ew3 as 32");
  endtask

  task automatic t_scalar;
    issue(3'd0, 2'd1, 2'd0, 32'h0102_0304, 32'h0, 32'h1234_5678, 1'b0, 1'b0, "R6 splat e8");
    issue(3'd1, 2'd1, 2'd1, 32'h0000_0000, 32'h0, 32'hABCD_0001, 1'b0, 1'b0, "R6 splat e16");
  endtask

  task automatic t_accumulate;
    issue(3'd4, 2'd3, 2'd0, 32'h0, 32'h0, 32'h0000_0005, 1'b0, 1'b0, "R7 mov ax loads acc");
    issue(3'd0, 2'd2, 2'd0, 32'h0102_0304, 32'h0, 32'h0, 1'b0, 1'b0, "R5 R7 add av");
    issue(3'd0, 2'd0, 2'd0, 32'h7777_7777, 32'h1111_1111, 32'h0, 1'b0, 1'b0, "R7 vv beat");
    issue(3'd0, 2'd1, 2'd0, 32'h3333_3333, 32'h0, 32'h0000_0002, 1'b0, 1'b0, "R7 vx beat");
    readback("R7 acc untouched by vector forms");
  endtask

  task automatic t_macc_stream;
    issue(3'd4, 2'd3, 2'd2, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, "R8 start clear");
    issue(3'd3, 2'd2, 2'd0, 32'h0102_0304, 32'h0506_0708, 32'h0, 1'b0, 1'b0, "R8 macc av beat0");
    issue(3'd3, 2'd2, 2'd0, 32'h1112_1314, 32'h0203_0405, 32'h0, 1'b0, 1'b0, "R8 macc av beat1");
    issue(3'd3, 2'd3, 2'd0, 32'h0, 32'h0A0B_0C0D, 32'h0000_0003, 1'b0, 1'b0, "R8 macc ax beat2");
    issue(3'd3, 2'd2, 2'd0, 32'hFF80_7F01, 32'hFF02_0290, 32'h0, 1'b0, 1'b0, "R8 macc av wrap beat3");
    readback("R8 final acc");
  endtask

  task automatic t_clear;
    @(negedge clk); clr = 1'b1;
    @(posedge clk); #1; clr = 1'b0; model_acc = '0;
    readback("R9 clear alone");
    chk(res === 32'h0, "R9 acc zero after clear", res, 32'h0);
    issue(3'd4, 2'd3, 2'd2, 32'h0, 32'h0, 32'h0000_0040, 1'b0, 1'b0, "R9 load");
    issue(3'd0, 2'd3, 2'd2, 32'h0, 32'h0, 32'h0000_0002, 1'b0, 1'b1, "R9 add with clear shows old sum");
    readback("R9 clear beats write");
    chk(res === 32'h0, "R9 acc zero after collision", res, 32'h0);
  endtask

  task automatic t_slide;
    issue(3'd5, 2'd0, 2'd0, 32'h0, 32'hA1B2_C3D4, 32'h0, 1'b1, 1'b0, "R10 slide first e8");
    issue(3'd0, 2'd0, 2'd0, 32'h1, 32'h2, 32'h0, 1'b0, 1'b0, "R10 unrelated beat");
    issue(3'd5, 2'd0, 2'd0, 32'h0, 32'h1122_3344, 32'h0, 1'b0, 1'b0, "R10 slide carries top e8");
    issue(3'd5, 2'd1, 2'd1, 32'h0, 32'h0, 32'hBEEF_5566, 1'b0, 1'b0, "R10 slide e16 scalar");
    issue(3'd5, 2'd2, 2'd1, 32'hDEAD_BEEF, 32'h0, 32'h0, 1'b0, 1'b0, "R10 slide into acc");
    readback("R10 acc after slide");
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_vector_ops();
    t_idle();
    t_widths();
    t_scalar();
    t_accumulate();
    t_macc_stream();
    t_idle();
    t_clear();
    t_slide();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule